// File: doc/BRIEF.md
# Wrapping Stack Address Generator

This block keeps the stack pointer of a small 8-bit processor and turns it into the 16-bit address used for each stacked byte. The stack holds 64 bytes at addresses 0x00C0 to 0x00FF. The upper ten address bits never change, so only a 6-bit offset is stored. When the stack runs past either end of that page, the offset simply wraps around. Nothing signals this wrap, and new bytes then overwrite old ones.

Two kinds of request drive the block. The first is a single-byte request, either a push or a pull. The second is a frame request from the instruction sequencer. A frame request makes the block step through a whole context save or restore on its own, one byte per cycle. A subroutine frame is two bytes and an interrupt frame is five bytes.

Every cycle the block reports the address to use and a write or read strobe. The memory array and the choice of which register's byte goes into each slot belong to the surrounding logic. A separate command puts the pointer back at the top of the page.

Top module: `stkp_wrap_top`

## Requirements
- R1: Bits 15 down to 6 of `stk_addr_o` are always 0000000011, so every address lies in 0x00C0..0x00FF.
- R2: After `rst_n` goes low, and in the cycle after `sp_reset_i` is sampled high, the pointer is 0x00FF. `sp_reset_i` outranks every other request and cancels any frame in progress. It raises no strobe in its own cycle.
- R3: A single push (`push_i` high, `pull_i` low) raises `stk_wr_o` and drives the current pointer onto `stk_addr_o`. The pointer is one lower in the next cycle.
- R4: A single pull raises `stk_rd_o` and drives the pointer plus one onto `stk_addr_o`. That incremented address becomes the new pointer.
- R5: A push at 0x00C0 leaves the pointer at 0x00FF. A pull at 0x00FF reads 0x00C0 and leaves the pointer there. No status is raised in either case.
- R6: With both `push_i` and `pull_i` high, no strobe is raised and the pointer keeps its value. With no request at all, no strobe is raised and `stk_addr_o` shows the pointer.
- R7: A frame push with `frame_irq_i` low (subroutine) writes two bytes in two consecutive cycles. The addresses step downward from the pointer.
- R8: A frame push with `frame_irq_i` high (interrupt) writes five bytes in five consecutive cycles. The addresses step downward.
- R9: A frame pull reads two bytes (`frame_irq_i` low) or five bytes (high) in consecutive cycles. Each read increments the pointer first.
- R10: `frame_busy_o` is high during every frame cycle after the first. In those cycles, single and frame requests other than `sp_reset_i` have no effect.
- R11: With `frame_push_i` and `frame_pull_i` both high while idle, no strobe is raised, no frame starts and the pointer holds.
- R12: A frame request that arrives while idle is served ahead of a single push or pull in the same cycle. The single request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp_reset_i | input | 1 | Reload the pointer to the top of the page |
| push_i | input | 1 | Push one byte |
| pull_i | input | 1 | Pull one byte |
| frame_push_i | input | 1 | Start a frame save |
| frame_pull_i | input | 1 | Start a frame restore |
| frame_irq_i | input | 1 | Frame size select: 0 = subroutine (2 bytes), 1 = interrupt (5 bytes) |
| stk_addr_o | output | 16 | Address of the byte accessed this cycle |
| stk_wr_o | output | 1 | A byte is written at `stk_addr_o` this cycle |
| stk_rd_o | output | 1 | A byte is read from `stk_addr_o` this cycle |
| frame_busy_o | output | 1 | Frame sequence continuing this cycle |

## Verification
The assertions check the per-cycle rules on every cycle:
- a push moves the pointer down by one;
- a pull adopts the address it reads;
- idle and conflicting cycles leave the pointer alone;
- both strobes are never high together;
- a reload always lands at the top;
- a frame request outranks a single request, and a running frame ignores new ones.

Some behaviours show only across several cycles, and only the bench scenarios reach them:
- the exact byte count and address run of each frame kind;
- a complete 64-step lap in both directions that returns to 0x00FF;
- a reload that cuts an interrupt frame short.

// File: rtl/stkp_pkg.sv
package stkp_pkg;

  // Operation applied to the pointer in the current cycle.
  typedef enum logic [1:0] {
    SOP_IDLE = 2'd0,
    SOP_PUSH = 2'd1,
    SOP_PULL = 2'd2,
    SOP_LOAD = 2'd3
  } stk_op_e;

  // Frame size select as seen on the frame_irq_i pin.
  typedef enum logic {
    FR_CALL = 1'b0,
    FR_IRQ  = 1'b1
  } frame_kind_e;

  // Direction of a frame sequence.
  typedef enum logic {
    FD_PULL = 1'b0,
    FD_PUSH = 1'b1
  } frame_dir_e;

endpackage

// File: rtl/stkp_frame_seq.sv
module stkp_frame_seq
  import stkp_pkg::*;
#(
  parameter int CALL_BYTES = 2,
  parameter int IRQ_BYTES  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort_i,
  input  logic        start_i,
  input  frame_dir_e  start_dir_i,
  input  frame_kind_e start_kind_i,
  output logic        busy_o,
  output frame_dir_e  dir_o
);

  localparam int MAX_BYTES = (CALL_BYTES > IRQ_BYTES) ? CALL_BYTES : IRQ_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  // Cycles still to run after the one that started the frame.
  function automatic logic [CNT_W-1:0] tail_len(frame_kind_e k);
    if (k == FR_IRQ) return CNT_W'(IRQ_BYTES - 1);
    else             return CNT_W'(CALL_BYTES - 1);
  endfunction

  logic [CNT_W-1:0] remain_q;
  frame_dir_e       dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      dir_q    <= FD_PUSH;
    end else if (abort_i) begin
      remain_q <= '0;
    end else if (start_i) begin
      remain_q <= tail_len(start_kind_i);
      dir_q    <= start_dir_i;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy_o = (remain_q != '0);
  assign dir_o  = dir_q;

  // R10: the arbiter never launches a frame while one is running.
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);

  // R7 / R8: the tail length loaded matches the frame kind.
  p_call_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i && start_kind_i == FR_CALL) |=> remain_q == CNT_W'(CALL_BYTES - 1));
  p_irq_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i && start_kind_i == FR_IRQ) |=> remain_q == CNT_W'(IRQ_BYTES - 1));

  // R10: a running frame counts down by one each cycle.
  p_countdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !abort_i) |=> remain_q == $past(remain_q) - 1'b1);

  // R2: a reload cancels the frame.
  p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !busy_o);

endmodule

// File: rtl/stkp_arb.sv
module stkp_arb
  import stkp_pkg::*;
(
  input  logic       rsp_i,
  input  logic       push_i,
  input  logic       pull_i,
  input  logic       fpush_i,
  input  logic       fpull_i,
  input  logic       busy_i,
  input  frame_dir_e dir_i,
  output stk_op_e    op_o,
  output logic       start_o,
  output frame_dir_e start_dir_o
);

  // Priority: reload, running frame, new frame, single byte.
  always_comb begin
    op_o        = SOP_IDLE;
    start_o     = 1'b0;
    start_dir_o = fpush_i ? FD_PUSH : FD_PULL;
    if (rsp_i) begin
      op_o = SOP_LOAD;
    end else if (busy_i) begin
      op_o = (dir_i == FD_PUSH) ? SOP_PUSH : SOP_PULL;
    end else if (fpush_i ^ fpull_i) begin
      start_o = 1'b1;
      op_o    = fpush_i ? SOP_PUSH : SOP_PULL;
    end else if (fpush_i && fpull_i) begin
      op_o = SOP_IDLE;
    end else if (push_i ^ pull_i) begin
      op_o = push_i ? SOP_PUSH : SOP_PULL;
    end
  end

endmodule

// File: rtl/stkp_core.sv
module stkp_core
  import stkp_pkg::*;
#(
  parameter int                        ADDR_W   = 16,
  parameter int                        PTR_W    = 6,
  parameter logic [ADDR_W-PTR_W-1:0]   PAGE_TAG = 'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic              rd_o
);

  // Offset arithmetic wraps naturally modulo 2**PTR_W.
  function automatic logic [PTR_W-1:0] off_dec(logic [PTR_W-1:0] x);
    return x - 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] off_inc(logic [PTR_W-1:0] x);
    return x + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] page_addr(logic [PTR_W-1:0] x);
    return {PAGE_TAG, x};
  endfunction

  logic [PTR_W-1:0] off_q;
  logic [PTR_W-1:0] off_up;

  assign off_up = off_inc(off_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '1;
    end else begin
      unique case (op_i)
        SOP_LOAD: off_q <= '1;
        SOP_PUSH: off_q <= off_dec(off_q);
        SOP_PULL: off_q <= off_up;
        default:  off_q <= off_q;
      endcase
    end
  end

  assign addr_o = page_addr((op_i == SOP_PULL) ? off_up : off_q);
  assign wr_o   = (op_i == SOP_PUSH);
  assign rd_o   = (op_i == SOP_PULL);

  // R3: a push writes at the old pointer, one above the new one.
  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SOP_PUSH) |=> PTR_W'(off_q + 1'b1) == $past(addr_o[PTR_W-1:0]));

  // R4: a pull leaves the pointer at the address it read.
  p_pull_adopt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SOP_PULL) |=> off_q == $past(addr_o[PTR_W-1:0]));

  // R5: pushing at the bottom of the page wraps to the top.
  p_wrap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SOP_PUSH && off_q == '0) |=> (&off_q));

  // R5: pulling at the top of the page wraps to the bottom.
  p_wrap_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SOP_PULL && (&off_q)) |=> off_q == '0);

  // R2: a reload lands at the top of the page.
  p_load_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SOP_LOAD) |=> (&off_q));

  // R6: an idle cycle keeps the pointer.
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SOP_IDLE) |=> $stable(off_q));

endmodule

// File: rtl/stkp_wrap_top.sv
module stkp_wrap_top
  import stkp_pkg::*;
#(
  parameter int                      ADDR_W     = 16,
  parameter int                      PTR_W      = 6,
  parameter logic [ADDR_W-PTR_W-1:0] PAGE_TAG   = 'b11,
  parameter int                      CALL_BYTES = 2,
  parameter int                      IRQ_BYTES  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_reset_i,
  input  logic              push_i,
  input  logic              pull_i,
  input  logic              frame_push_i,
  input  logic              frame_pull_i,
  input  logic              frame_irq_i,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic              stk_wr_o,
  output logic              stk_rd_o,
  output logic              frame_busy_o
);

  stk_op_e     op_w;
  logic        start_w;
  frame_dir_e  start_dir_w;
  frame_dir_e  run_dir_w;
  frame_kind_e kind_w;
  logic        busy_w;

  assign kind_w = frame_irq_i ? FR_IRQ : FR_CALL;

  stkp_arb u_arb (
    .rsp_i       (sp_reset_i),
    .push_i      (push_i),
    .pull_i      (pull_i),
    .fpush_i     (frame_push_i),
    .fpull_i     (frame_pull_i),
    .busy_i      (busy_w),
    .dir_i       (run_dir_w),
    .op_o        (op_w),
    .start_o     (start_w),
    .start_dir_o (start_dir_w)
  );

  stkp_frame_seq #(
    .CALL_BYTES (CALL_BYTES),
    .IRQ_BYTES  (IRQ_BYTES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_i      (sp_reset_i),
    .start_i      (start_w),
    .start_dir_i  (start_dir_w),
    .start_kind_i (kind_w),
    .busy_o       (busy_w),
    .dir_o        (run_dir_w)
  );

  stkp_core #(
    .ADDR_W   (ADDR_W),
    .PTR_W    (PTR_W),
    .PAGE_TAG (PAGE_TAG)
  ) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_w),
    .addr_o (stk_addr_o),
    .wr_o   (stk_wr_o),
    .rd_o   (stk_rd_o)
  );

  assign frame_busy_o = busy_w;

  // Never read and write in the same cycle.
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_wr_o, stk_rd_o}));

  // R6: conflicting single requests give no access.
  p_conflict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pull_i && !sp_reset_i && !busy_w && !frame_push_i && !frame_pull_i)
      |-> (!stk_wr_o && !stk_rd_o));

  // R12: a fresh frame request decides the access direction.
  p_frame_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_reset_i && !busy_w && (frame_push_i ^ frame_pull_i))
      |-> (stk_wr_o == frame_push_i && stk_rd_o == frame_pull_i));

  // R11: conflicting frame requests start nothing.
  p_frame_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_reset_i && !busy_w && frame_push_i && frame_pull_i)
      |-> (!stk_wr_o && !stk_rd_o) ##1 !frame_busy_o);

  // R10: a running frame keeps its direction whatever arrives.
  p_frame_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !sp_reset_i) |-> (stk_wr_o == (run_dir_w == FD_PUSH)) && (stk_rd_o != stk_wr_o));

  // R2: a reload raises no strobe.
  p_reload_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_reset_i |-> (!stk_wr_o && !stk_rd_o));

endmodule

// File: tb/sim_stkp_wrap_top.sv
module sim_stkp_wrap_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_reset_i = 1'b0;
  logic        push_i = 1'b0;
  logic        pull_i = 1'b0;
  logic        frame_push_i = 1'b0;
  logic        frame_pull_i = 1'b0;
  logic        frame_irq_i = 1'b0;
  logic [15:0] stk_addr_o;
  logic        stk_wr_o;
  logic        stk_rd_o;
  logic        frame_busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stkp_wrap_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sp_reset_i   (sp_reset_i),
    .push_i       (push_i),
    .pull_i       (pull_i),
    .frame_push_i (frame_push_i),
    .frame_pull_i (frame_pull_i),
    .frame_irq_i  (frame_irq_i),
    .stk_addr_o   (stk_addr_o),
    .stk_wr_o     (stk_wr_o),
    .stk_rd_o     (stk_rd_o),
    .frame_busy_o (frame_busy_o)
  );

  // Row: {reset, push, pull, fpush, fpull, irq} {addr} {wr, rd, busy}
  localparam int NV = 32;
  localparam logic [24:0] TBL [0:NV-1] = '{
    {6'b000000, 16'h00FF, 3'b000},
    {6'b010000, 16'h00FF, 3'b100},
    {6'b010000, 16'h00FE, 3'b100},
    {6'b011000, 16'h00FD, 3'b000},
    {6'b001000, 16'h00FE, 3'b010},
    {6'b001000, 16'h00FF, 3'b010},
    {6'b001000, 16'h00C0, 3'b010},
    {6'b010000, 16'h00C0, 3'b100},
    {6'b000000, 16'h00FF, 3'b000},
    {6'b000100, 16'h00FF, 3'b100},
    {6'b000000, 16'h00FE, 3'b101},
    {6'b000000, 16'h00FD, 3'b000},
    {6'b000101, 16'h00FD, 3'b100},
    {6'b001000, 16'h00FC, 3'b101},
    {6'b000000, 16'h00FB, 3'b101},
    {6'b000000, 16'h00FA, 3'b101},
    {6'b000000, 16'h00F9, 3'b101},
    {6'b000000, 16'h00F8, 3'b000},
    {6'b000011, 16'h00F9, 3'b010},
    {6'b000000, 16'h00FA, 3'b011},
    {6'b000000, 16'h00FB, 3'b011},
    {6'b000000, 16'h00FC, 3'b011},
    {6'b000000, 16'h00FD, 3'b011},
    {6'b000000, 16'h00FD, 3'b000},
    {6'b010100, 16'h00FD, 3'b100},
    {6'b000000, 16'h00FC, 3'b101},
    {6'b000110, 16'h00FB, 3'b000},
    {6'b000010, 16'h00FC, 3'b010},
    {6'b000100, 16'h00FD, 3'b011},
    {6'b000000, 16'h00FD, 3'b000},
    {6'b100000, 16'h00FD, 3'b000},
    {6'b000000, 16'h00FF, 3'b000}
  };

  function automatic string row_tag(int i);
    if (i <= 2)  return "R3";
    if (i == 3)  return "R6";
    if (i <= 5)  return "R4";
    if (i <= 8)  return "R5";
    if (i <= 11) return "R7";
    if (i <= 17) return "R8";
    if (i <= 23) return "R9";
    if (i <= 25) return "R12";
    if (i == 26) return "R11";
    if (i <= 29) return "R10";
    return "R2";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] s);
    @(negedge clk);
    {sp_reset_i, push_i, pull_i, frame_push_i, frame_pull_i, frame_irq_i} = s;
    #2;
  endtask

  task automatic chk_out(string tag, logic [15:0] a, logic w, logic r, logic b);
    chk(tag, stk_addr_o, a);
    chk(tag, {13'd0, stk_wr_o, stk_rd_o, frame_busy_o}, {13'd0, w, r, b});
    chk("R1", {6'd0, stk_addr_o[15:6]}, 16'h0003);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [5:0] m;
    // R2: reset state
    repeat (2) @(negedge clk);
    #2;
    chk_out("R2", 16'h00FF, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][24:19]);
      chk_out(row_tag(i), TBL[i][18:3], TBL[i][2], TBL[i][1], TBL[i][0]);
    end

    // R5: full lap downward and back upward
    m = 6'h3F;
    for (int k = 0; k < 64; k++) begin
      drive(6'b010000);
      chk_out("R5", {10'b0000000011, m}, 1'b1, 1'b0, 1'b0);
      m = m - 6'd1;
    end
    drive(6'b000000);
    chk_out("R5", 16'h00FF, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 64; k++) begin
      m = m + 6'd1;
      drive(6'b001000);
      chk_out("R5", {10'b0000000011, m}, 1'b0, 1'b1, 1'b0);
    end
    drive(6'b000000);
    chk_out("R5", 16'h00FF, 1'b0, 1'b0, 1'b0);

    // R2: reload cuts an interrupt frame short
    drive(6'b000101);
    chk_out("R8", 16'h00FF, 1'b1, 1'b0, 1'b0);
    drive(6'b000000);
    chk_out("R8", 16'h00FE, 1'b1, 1'b0, 1'b1);
    drive(6'b110000);
    chk_out("R2", 16'h00FD, 1'b0, 1'b0, 1'b1);
    drive(6'b000000);
    chk_out("R2", 16'h00FF, 1'b0, 1'b0, 1'b0);

    // R2: asynchronous reset from a moved pointer
    drive(6'b010000);
    drive(6'b000000);
    chk_out("R3", 16'h00FE, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #2;
    chk_out("R2", 16'h00FF, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    drive(6'b000000);
    finish_run();
  end

endmodule